// File: doc/BRIEF.md
# Vector AES Middle-Round Engine

This engine applies one AES encryption middle round to each 128-bit element group of a vector register image. The caller presents the destination register contents (the current cipher state, one state per group) and the source register contents (one round key per group), together with the vector length, start index, element-width code and register-grouping code, and pulses `start`. The engine checks the configuration first. If the configuration is legal, it takes a copy of both operands and then updates one group per clock, beginning at the group holding element `vstart` and stopping before the group holding element `vl`. When it finishes it pulses `done`. The updated register image is on `vd_out`.

Each group is four 32-bit elements. Element i is state column i, and byte r of that column sits at bits 8r+7..8r of the element, so state byte k = r + 4c occupies bits 8k+7..8k of the group. A group's new value is SubBytes, then ShiftRows, then MixColumns over GF(2^8) with polynomial 0x11B, and then an XOR with the key group. The operation has no mask. Every group in the active range is written and every group outside it keeps its value. A bad configuration raises `illegal` together with `done`, and no group is changed.

Top module: `vaes_mid_round`

## Requirements
- R1: Each active group becomes MixColumns(ShiftRows(SubBytes(state))) XOR key. The layout is byte k = row + 4*column at group bits 8k+7..8k, and group g is at `vd_in`/`vd_out` bits 128g+127..128g.
- R2: Only groups g with 4g >= vstart and 4g < vl are updated. All other groups of `vd_out` equal `vd_in` as captured at start. For N active groups, `done` is high N+1 cycles after the start edge.
- R3: `done` is a single-cycle pulse. An empty range (vstart >= vl) gives `done` on the cycle after start and leaves `vd_out` equal to `vd_in`. While idle, `vd_out` holds its value.
- R4: The element-width code `sew` must be 3'b010 (32 bits). Any other code raises `illegal` and `done` on the cycle after start, with `vd_out` equal to `vd_in`.
- R5: If vl or vstart is not a multiple of 4, the request is illegal in the same way as R4.
- R6: The register-group size comes from `lmul`: 000=1x, 001=2x, 010=4x, 011=8x, 101=1/8, 110=1/4 and 111=1/2 of VLEN bits. Code 100 is illegal. A size below 128 bits is illegal. A vl above size/32 is illegal.
- R7: `vstart_out` equals the element index of the group being processed while busy, and 0 otherwise. In particular it is 0 when `done` is high.
- R8: A `start` pulse while busy is ignored. It raises no `illegal` and does not alter the run in progress.
- R9: After reset, `vd_out`, `vstart_out`, `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation |
| sew | input | 3 | Element-width code (010 = 32 bits) |
| lmul | input | 3 | Register-grouping code |
| vl | input | VLW | Vector length in elements |
| vstart | input | VLW | First element to process |
| vd_in | input | 8*VLEN | State register image |
| vs2_in | input | 8*VLEN | Round-key register image |
| vd_out | output | 8*VLEN | Updated register image |
| vstart_out | output | VLW | Current element position, 0 when idle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-configuration pulse |

## Verification
A corrupt group index or end bound shows up as soon as `done` arrives. One of three things is visible: a group outside [vstart, vl) has been rewritten, a group inside the range still holds its old state, or `done` comes earlier or later than N+1 cycles. A fault in the S-box, the row rotation or the column mix damages specific bytes of the finished group. Known-answer round values locate that damage to a byte position. A legality fault appears the cycle after start, as a missing or spurious `illegal` or as a register image that changed when it should not have.

// File: rtl/vaes_mid_round.sv
module vaes_mid_round #(
  parameter int VLEN     = 128,
  parameter int LMUL_MAX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           sew,
  input  logic [2:0]           lmul,
  input  logic [$clog2(VLEN*LMUL_MAX/32+1)-1:0] vl,
  input  logic [$clog2(VLEN*LMUL_MAX/32+1)-1:0] vstart,
  input  logic [VLEN*LMUL_MAX-1:0] vd_in,
  input  logic [VLEN*LMUL_MAX-1:0] vs2_in,
  output logic [VLEN*LMUL_MAX-1:0] vd_out,
  output logic [$clog2(VLEN*LMUL_MAX/32+1)-1:0] vstart_out,
  output logic                 done,
  output logic                 illegal
);
  localparam int MAXB = VLEN * LMUL_MAX;
  localparam int NG   = MAXB / 128;
  localparam int VLW  = $clog2(MAXB / 32 + 1);
  localparam int GIW  = VLW - 2;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] r, s, b;
    r = 8'h01;
    s = a;
    for (int i = 1; i < 8; i++) begin
      s = gmul(s, s);
      r = gmul(r, s);
    end
    b = r;
    return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]} ^ {b[4:0], b[7:5]}
             ^ {b[3:0], b[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [127:0] mid_round(input logic [127:0] st, input logic [127:0] key);
    logic [7:0] sb [16];
    logic [7:0] sr [16];
    logic [127:0] mc;
    logic [7:0] a0, a1, a2, a3;
    for (int k = 0; k < 16; k++) sb[k] = sbox(st[8*k +: 8]);
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        sr[r + 4*c] = sb[r + 4*((c + r) % 4)];
    for (int c = 0; c < 4; c++) begin
      a0 = sr[4*c]; a1 = sr[4*c+1]; a2 = sr[4*c+2]; a3 = sr[4*c+3];
      mc[32*c +: 8]      = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
      mc[32*c + 8 +: 8]  = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
      mc[32*c + 16 +: 8] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
      mc[32*c + 24 +: 8] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
    end
    return mc ^ key;
  endfunction

  function automatic int reg_bits(input logic [2:0] code);
    case (code)
      3'b000:  return VLEN;
      3'b001:  return 2 * VLEN;
      3'b010:  return 4 * VLEN;
      3'b011:  return 8 * VLEN;
      3'b101:  return VLEN / 8;
      3'b110:  return VLEN / 4;
      3'b111:  return VLEN / 2;
      default: return 0;
    endcase
  endfunction

  logic [MAXB-1:0] vd_q, vs2_q;
  logic [GIW-1:0]  idx, last;
  logic            busy;
  logic [127:0]    cur_st, cur_key, rnd_out;
  int              regb;
  logic            bad;

  assign regb = reg_bits(lmul);
  assign bad  = (sew != 3'b010) || (vl[1:0] != 2'b00) || (vstart[1:0] != 2'b00) ||
                (regb < 128) || (regb > MAXB) || (int'(vl) > regb / 32);

  always_comb begin
    cur_st  = '0;
    cur_key = '0;
    for (int g = 0; g < NG; g++)
      if (idx == GIW'(g)) begin
        cur_st  = vd_q[128*g +: 128];
        cur_key = vs2_q[128*g +: 128];
      end
  end

  assign rnd_out    = mid_round(cur_st, cur_key);
  assign vd_out     = vd_q;
  assign vstart_out = busy ? {idx, 2'b00} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q    <= '0;
      vs2_q   <= '0;
      idx     <= '0;
      last    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        for (int g = 0; g < NG; g++)
          if (idx == GIW'(g)) vd_q[128*g +: 128] <= rnd_out;
        idx <= idx + GIW'(1);
        if (idx == last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        vd_q  <= vd_in;
        vs2_q <= vs2_in;
        if (bad) begin
          illegal <= 1'b1;
          done    <= 1'b1;
        end else if (vstart >= vl) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          idx  <= vstart[VLW-1:2];
          last <= vl[VLW-1:2] - GIW'(1);
        end
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  illegal_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && !busy);
  // R4
  illegal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> vd_out == $past(vd_in));
  // R7
  vstart_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || vstart_out == $past(vstart_out) + VLW'(4));
  // R7
  vstart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> vstart_out == '0);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> !illegal);
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(vd_out));
endmodule

// File: tb/tb_vaes_mid_round.sv
`timescale 1ns/1ps
module tb_vaes_mid_round;
  localparam int VLEN = 128;
  localparam int MAXB = VLEN * 8;
  localparam int VLW  = $clog2(MAXB / 32 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] sew = 3'b010, lmul = 3'b000;
  logic [VLW-1:0] vl = '0, vstart = '0;
  logic [MAXB-1:0] vd_in = '0, vs2_in = '0;
  logic [MAXB-1:0] vd_out;
  logic [VLW-1:0] vstart_out;
  logic done, illegal;

  int checks = 0, fails = 0;
  int cyc;
  logic saw_ill;

  always #2.5 clk = ~clk;

  vaes_mid_round #(.VLEN(VLEN), .LMUL_MAX(8)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sew(sew), .lmul(lmul),
    .vl(vl), .vstart(vstart), .vd_in(vd_in), .vs2_in(vs2_in),
    .vd_out(vd_out), .vstart_out(vstart_out), .done(done), .illegal(illegal));

  // {state, key, expected} as FIPS byte strings, first byte leftmost
  localparam logic [383:0] VEC [4] = '{
    {128'h193de3bea0f4e22b9ac68d2ae9f84808, 128'ha0fafe1788542cb123a339392a6c7605,
     128'ha49c7ff2689f352b6b5bea43026a5049},
    {128'ha49c7ff2689f352b6b5bea43026a5049, 128'hf2c295f27a96b9435935807a7359f67f,
     128'haa8f5f0361dde3ef82d24ad26832469a},
    {128'haa8f5f0361dde3ef82d24ad26832469a, 128'h3d80477d4716fe3e1e237e446d7a883b,
     128'h486c4eee671d9d0d4de3b138d65f58e7},
    {128'h0, 128'h0, 128'h63636363636363636363636363636363}
  };

  function automatic logic [127:0] pk(input logic [127:0] s);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = s[8*(15-k) +: 8];
    return r;
  endfunction

  function automatic logic [127:0] st(input int i);  return pk(VEC[i][383:256]); endfunction
  function automatic logic [127:0] ky(input int i);  return pk(VEC[i][255:128]); endfunction
  function automatic logic [127:0] ex(input int i);  return pk(VEC[i][127:0]);   endfunction

  task automatic chk(input logic ok, input string req, input logic [MAXB-1:0] act,
                     input logic [MAXB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] s, input logic [2:0] lm, input int l, input int vs);
    @(negedge clk);
    sew = s; lmul = lm; vl = VLW'(l); vstart = VLW'(vs); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    saw_ill = illegal;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    saw_ill = illegal;
  endtask

  task automatic expect_illegal(input string req, input logic [2:0] s, input logic [2:0] lm,
                                input int l, input int vs);
    vd_in = {8{st(2)}};
    vs2_in = {8{ky(2)}};
    run(s, lm, l, vs);
    chk(saw_ill && cyc == 1, req, MAXB'(cyc), MAXB'(1));
    chk(vd_out == vd_in, req, vd_out, vd_in);
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #12;
    // R9 reset state
    chk(vd_out == '0 && done == 0 && illegal == 0 && vstart_out == '0, "R9",
        vd_out, '0);
    rst_n = 1'b1;

    // R1 table walk: one group, LMUL 1x
    for (int i = 0; i < 4; i++) begin
      vd_in = '0; vs2_in = '0;
      vd_in[127:0] = st(i);
      vs2_in[127:0] = ky(i);
      run(3'b010, 3'b000, 4, 0);
      chk(vd_out[127:0] == ex(i), "R1", MAXB'(vd_out[127:0]), MAXB'(ex(i)));
      chk(cyc == 2 && !saw_ill, "R2", MAXB'(cyc), MAXB'(2));
    end

    // R2 full range over four groups, LMUL 4x
    for (int g = 0; g < 4; g++) begin
      vd_in[128*g +: 128] = st(g);
      vs2_in[128*g +: 128] = ky(g);
    end
    run(3'b010, 3'b010, 16, 0);
    chk(cyc == 5, "R2", MAXB'(cyc), MAXB'(5));
    for (int g = 0; g < 4; g++)
      chk(vd_out[128*g +: 128] == ex(g), "R1", MAXB'(vd_out[128*g +: 128]), MAXB'(ex(g)));

    // R2 partial range vstart=4 vl=12, with R7 position check
    @(negedge clk);
    lmul = 3'b010; vl = VLW'(12); vstart = VLW'(4); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(vstart_out == VLW'(4), "R7", MAXB'(vstart_out), MAXB'(4));
    // R8 start while busy with bad width code
    sew = 3'b011; start = 1'b1;
    @(negedge clk);
    start = 1'b0; sew = 3'b010;
    chk(vstart_out == VLW'(8) && !illegal, "R8", MAXB'(vstart_out), MAXB'(8));
    @(negedge clk);
    chk(done && !illegal, "R2", MAXB'(done), MAXB'(1));
    chk(vstart_out == '0, "R7", MAXB'(vstart_out), '0);
    chk(vd_out[127:0] == st(0) && vd_out[511:384] == st(3), "R2", vd_out, vd_in);
    chk(vd_out[255:128] == ex(1) && vd_out[383:256] == ex(2), "R2", vd_out, vd_in);
    @(negedge clk);
    chk(!done, "R3", MAXB'(done), '0);

    // R3 empty range
    run(3'b010, 3'b010, 8, 8);
    chk(cyc == 1 && !saw_ill && vd_out == vd_in, "R3", MAXB'(cyc), MAXB'(1));

    // R3 idle hold
    vd_in = '1;
    repeat (3) @(negedge clk);
    chk(vd_out != vd_in, "R3", vd_out, ~vd_in);

    expect_illegal("R4", 3'b011, 3'b000, 4, 0);
    expect_illegal("R4", 3'b001, 3'b000, 4, 0);
    expect_illegal("R5", 3'b010, 3'b010, 6, 0);
    expect_illegal("R5", 3'b010, 3'b010, 12, 2);
    expect_illegal("R6", 3'b010, 3'b111, 4, 0);
    expect_illegal("R6", 3'b010, 3'b100, 4, 0);
    expect_illegal("R6", 3'b010, 3'b000, 8, 0);

    // R6 largest legal grouping, 8x, last group only
    vd_in = '0; vs2_in = '0;
    vd_in[1023:896] = st(0);
    vs2_in[1023:896] = ky(0);
    run(3'b010, 3'b011, 32, 28);
    chk(!saw_ill && cyc == 2 && vd_out[1023:896] == ex(0), "R6",
        MAXB'(vd_out[1023:896]), MAXB'(ex(0)));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule